// File: doc/BRIEF.md
# Bus-Mapped Serial Port with Flag Interrupt

This block is a fixed-rate asynchronous serial transmitter and receiver that sits on a Wishbone bus as a slave. The line format is one low start bit, eight data bits least significant first and one high stop bit, and the line rests high. A build-time parameter gives the bit period in clock cycles. No register changes the line settings at run time.

Software sees two 32-bit words. One word is shared by both directions: a store to it hands a character to the transmitter, and a load from it returns the last character received and frees the receive slot. The other word holds two flags, "a received character is waiting" and "the transmitter can take a character". The interrupt pin is raised while either flag is set. Software can therefore drive the port either by polling the flag word or from the interrupt.

Top module: `sbus_uart`

## Requirements
- R1: After reset the serial output is high, the interrupt output is high and the flag word (word offset 1) reads 0x00000002.
- R2: A store to word offset 0 with byte lane 0 enabled sends bits [7:0] of the write data as one frame: a low start bit, the eight data bits least significant first and a high stop bit, each held for CLKS_PER_BIT clocks. The line is high whenever no frame is being sent.
- R3: Bit 1 of the flag word (transmitter empty) reads 0 from the accepted store until the stop bit has ended, and reads 1 again after that.
- R4: A store to word offset 0 while a frame is being sent is acknowledged but has no effect: the frame in progress completes unchanged and no further frame follows.
- R5: A valid received frame sets bit 0 of the flag word (receive full). A load from word offset 0 then returns the character in bits [7:0], with bits [31:8] zero.
- R6: A load from word offset 0 clears bit 0 of the flag word, unless a new frame completes in the same cycle.
- R7: A frame that completes while bit 0 is still set replaces the held character.
- R8: A low pulse on the serial input that is shorter than half a bit period is treated as noise. No character is received.
- R9: A frame whose stop bit samples low is discarded and leaves bit 0 clear. The receiver then waits for the line to go high and accepts the next valid frame.
- R10: The interrupt output is high exactly when bit 0 or bit 1 of the flag word is set.
- R11: Every request is acknowledged by a one-cycle ack in the cycle after it is presented. Loads from offsets other than 0 and 1 return zero. Stores to the flag word have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle in progress |
| wb_stb_i | input | 1 | Strobe for this slave |
| wb_we_i | input | 1 | 1 = store, 0 = load |
| wb_adr_i | input | ADDR_W | Word address |
| wb_dat_i | input | DATA_W | Store data |
| wb_sel_i | input | DATA_W/8 | Byte lane enables |
| wb_dat_o | output | DATA_W | Load data |
| wb_ack_o | output | 1 | One-cycle acknowledge |
| uart_rx_i | input | 1 | Serial input |
| uart_tx_o | output | 1 | Serial output |
| irq_o | output | 1 | Interrupt, OR of the two flags |

## Verification
Several cases only appear when bus traffic and line traffic overlap in time. These are a store arriving while a frame is being shifted out, a character arriving while the transmitter is busy, and a second character landing before the first is read. The bench reaches them by forking a line driver, a bus sequence and a serial monitor with fixed cycle offsets between them. Runts shorter than half a bit and frames with a low stop bit are driven directly on the serial input. After each one the flag word is read back, and a clean frame is then sent to show that the receiver has recovered.

// File: rtl/sbus_uart_pkg.sv
package sbus_uart_pkg;

  // Word offsets decoded on the bus.
  localparam int unsigned DATA_OFS = 0;
  localparam int unsigned FLAG_OFS = 1;

  // Character width of the serial frame.
  localparam int unsigned CHAR_W = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BREAK
  } rx_state_e;

endpackage

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned CHAR_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CHAR_W-1:0] din,
  output logic              txd,
  output logic              busy
);
  localparam int unsigned CW   = $clog2(CLKS_PER_BIT);
  localparam int unsigned IW   = $clog2(CHAR_W + 2);
  localparam int unsigned LAST = CHAR_W + 1;

  logic [CW-1:0]   cnt;
  logic [IW-1:0]   idx;
  logic [CHAR_W:0] frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      txd   <= 1'b1;
      cnt   <= '0;
      idx   <= '0;
      frame <= '1;
    end else if (!busy) begin
      txd <= 1'b1;
      if (start) begin
        busy  <= 1'b1;
        txd   <= 1'b0;
        frame <= {1'b1, din};
        cnt   <= '0;
        idx   <= '0;
      end
    end else if (cnt == CW'(CLKS_PER_BIT - 1)) begin
      cnt <= '0;
      if (idx == IW'(LAST)) begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end else begin
        txd   <= frame[0];
        frame <= {1'b1, frame[CHAR_W:1]};
        idx   <= idx + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/uart_rx_sample.sv
module uart_rx_sample
  import sbus_uart_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned CHAR_W       = 8,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  output logic              valid,
  output logic [CHAR_W-1:0] dout
);
  localparam int unsigned CW   = $clog2(CLKS_PER_BIT);
  localparam int unsigned IW   = $clog2(CHAR_W);
  localparam int unsigned HALF = CLKS_PER_BIT / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line;
  rx_state_e              state;
  logic [CW-1:0]          cnt;
  logic [IW-1:0]          idx;
  logic [CHAR_W-1:0]      shreg;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end
  assign line = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
      valid <= 1'b0;
      dout  <= '0;
    end else begin
      valid <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (!line) state <= RX_START;
        end
        RX_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt   <= '0;
            idx   <= '0;
            state <= line ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == CW'(CLKS_PER_BIT - 1)) begin
            cnt   <= '0;
            shreg <= {line, shreg[CHAR_W-1:1]};
            if (idx == IW'(CHAR_W - 1)) state <= RX_STOP;
            else                        idx   <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt == CW'(CLKS_PER_BIT - 1)) begin
            cnt <= '0;
            if (line) begin
              valid <= 1'b1;
              dout  <= shreg;
              state <= RX_IDLE;
            end else begin
              state <= RX_BREAK;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_BREAK: begin
          if (line) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sbus_uart.sv
module sbus_uart
  import sbus_uart_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned ADDR_W       = 2,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wb_cyc_i,
  input  logic                 wb_stb_i,
  input  logic                 wb_we_i,
  input  logic [ADDR_W-1:0]    wb_adr_i,
  input  logic [DATA_W-1:0]    wb_dat_i,
  input  logic [DATA_W/8-1:0]  wb_sel_i,
  output logic [DATA_W-1:0]    wb_dat_o,
  output logic                 wb_ack_o,
  input  logic                 uart_rx_i,
  output logic                 uart_tx_o,
  output logic                 irq_o
);
  localparam int unsigned SEL_W = DATA_W / 8;

  logic              req;
  logic              data_hit;
  logic              wr_data_hit;
  logic              rd_data_hit;
  logic              tx_busy;
  logic              tx_empty;
  logic              rx_valid;
  logic [CHAR_W-1:0] rx_char;
  logic [CHAR_W-1:0] rx_hold;
  logic              rx_full;
  logic              unused_bits;

  assign req         = wb_cyc_i && wb_stb_i && !wb_ack_o;
  assign data_hit    = (wb_adr_i == ADDR_W'(DATA_OFS));
  assign wr_data_hit = req && wb_we_i && data_hit && wb_sel_i[0];
  assign rd_data_hit = req && !wb_we_i && data_hit;
  assign unused_bits = ^{wb_dat_i[DATA_W-1:CHAR_W], wb_sel_i[SEL_W-1:1]};

  uart_tx_shift #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .CHAR_W      (CHAR_W)
  ) u_tx (
    .clk  (clk),
    .rst  (rst),
    .start(wr_data_hit),
    .din  (wb_dat_i[CHAR_W-1:0]),
    .txd  (uart_tx_o),
    .busy (tx_busy)
  );

  uart_rx_sample #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .CHAR_W      (CHAR_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_rx (
    .clk  (clk),
    .rst  (rst),
    .rxd  (uart_rx_i),
    .valid(rx_valid),
    .dout (rx_char)
  );

  assign tx_empty = !tx_busy;

  // Receive holding slot: a new character always wins over a clearing load.
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_full <= 1'b0;
      rx_hold <= '0;
    end else if (rx_valid) begin
      rx_full <= 1'b1;
      rx_hold <= rx_char;
    end else if (rd_data_hit) begin
      rx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_ack_o <= 1'b0;
      wb_dat_o <= '0;
    end else begin
      wb_ack_o <= req;
      wb_dat_o <= '0;
      if (req && !wb_we_i) begin
        if (data_hit)
          wb_dat_o <= DATA_W'(rx_hold);
        else if (wb_adr_i == ADDR_W'(FLAG_OFS))
          wb_dat_o <= DATA_W'({tx_empty, rx_full});
      end
    end
  end

  assign irq_o = rx_full || tx_empty;

endmodule

// File: rtl/sbus_uart_chk.sv
module sbus_uart_chk (
  input logic clk,
  input logic rst,
  input logic wb_cyc_i,
  input logic wb_stb_i,
  input logic wb_ack_o,
  input logic uart_tx_o,
  input logic tx_busy,
  input logic rx_valid,
  input logic rx_full,
  input logic rd_data_hit
);

  // R11
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o);

  // R11
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    wb_ack_o |=> !wb_ack_o);

  // R5
  rx_sets_full_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> rx_full);

  // R6
  rd_clears_full_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data_hit && !rx_valid) |=> !rx_full);

  // R2
  start_only_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(uart_tx_o) |-> tx_busy);

  // R2
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> uart_tx_o);

endmodule

bind sbus_uart sbus_uart_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .wb_cyc_i   (wb_cyc_i),
  .wb_stb_i   (wb_stb_i),
  .wb_ack_o   (wb_ack_o),
  .uart_tx_o  (uart_tx_o),
  .tx_busy    (tx_busy),
  .rx_valid   (rx_valid),
  .rx_full    (rx_full),
  .rd_data_hit(rd_data_hit)
);

// File: tb/sbus_uart_bench.sv
`timescale 1ns/1ps
module sbus_uart_bench;
  localparam int CPB    = 16;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] adr = '0;
  logic [DATA_W-1:0] wdat = '0;
  logic [3:0]        sel = 4'h0;
  logic [DATA_W-1:0] rdat;
  logic              ack;
  logic              rxd = 1'b1;
  logic              txd;
  logic              irq;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  sbus_uart #(.CLKS_PER_BIT(CPB), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sbus_uart (
    .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_sel_i(sel), .wb_dat_o(rdat),
    .wb_ack_o(ack), .uart_rx_i(rxd), .uart_tx_o(txd), .irq_o(irq)
  );

  function automatic logic [31:0] flag_word(input logic rx_full, input logic tx_empty);
    return {30'b0, tx_empty, rx_full};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_xfer(input logic w, input logic [ADDR_W-1:0] a,
                          input logic [31:0] d, output logic [31:0] q);
    int waited = 0;
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d; sel = 4'hF;
    @(negedge clk);
    while (!ack && waited < 8) begin
      waited++;
      @(negedge clk);
    end
    // R11: ack one cycle after the request
    chk("R11 ack latency", 32'(waited), 32'd0);
    q = rdat;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    bus_xfer(1'b1, a, d, dummy);
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] q);
    bus_xfer(1'b0, a, 32'h0, q);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop);
    @(negedge clk); rxd = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (CPB) @(negedge clk);
    end
    rxd = stop;
    repeat (CPB) @(negedge clk);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic capture_tx(output logic [7:0] b, output logic ok);
    int guard = 0;
    logic st, sp;
    b = 8'h00;
    while (txd !== 1'b0 && guard < 40 * CPB) begin
      @(negedge clk);
      guard++;
    end
    repeat (CPB / 2) @(negedge clk);
    st = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (CPB) @(negedge clk);
      b[i] = txd;
    end
    repeat (CPB) @(negedge clk);
    sp = txd;
    ok = (guard < 40 * CPB) && (st === 1'b0) && (sp === 1'b1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    logic [7:0]  b, b2, got;
    logic        ok;
    int          lows;
    void'($urandom(32'd20240611));

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 tx idle", 32'(txd), 32'd1);
    chk("R1 irq", 32'(irq), 32'd1);
    bus_read(2'd1, q);
    chk("R1 flag word", q, flag_word(1'b0, 1'b1));

    // R2/R3: random transmit frames
    for (int n = 0; n < 6; n++) begin
      b = 8'($urandom);
      fork
        capture_tx(got, ok);
        begin
          bus_write(2'd0, {24'($urandom), b});
          @(negedge clk);
          // R10: both flags clear while sending
          chk("R10 irq low while busy", 32'(irq), 32'd0);
          bus_read(2'd1, q);
          chk("R3 tx not empty while sending", q, flag_word(1'b0, 1'b0));
        end
      join
      chk("R2 frame shape", 32'(ok), 32'd1);
      chk("R2 frame data", 32'(got), 32'(b));
      repeat (CPB) @(negedge clk);
      bus_read(2'd1, q);
      chk("R3 tx empty after stop", q, flag_word(1'b0, 1'b1));
    end

    // R4: store while busy is ignored
    b = 8'hA5; b2 = 8'h3C;
    fork
      capture_tx(got, ok);
      begin
        bus_write(2'd0, {24'h0, b});
        repeat (20) @(negedge clk);
        bus_write(2'd0, {24'h0, b2});
      end
    join
    chk("R4 first frame kept", 32'(got), 32'(b));
    lows = 0;
    repeat (12 * CPB) begin
      @(negedge clk);
      if (txd === 1'b0) lows++;
    end
    chk("R4 no second frame", 32'(lows), 32'd0);

    // R5/R6: random receive frames, including zero and all-ones
    for (int n = 0; n < 6; n++) begin
      b = (n == 0) ? 8'h00 : (n == 1) ? 8'hFF : 8'($urandom);
      send_rx(b, 1'b1);
      chk("R10 irq with rx full", 32'(irq), 32'd1);
      bus_read(2'd1, q);
      chk("R5 rx full flag", q, flag_word(1'b1, 1'b1));
      bus_read(2'd0, q);
      chk("R5 rx data", q, {24'h0, b});
      bus_read(2'd1, q);
      chk("R6 read clears rx full", q, flag_word(1'b0, 1'b1));
    end

    // R10: character arrives while transmitter busy
    b = 8'($urandom); b2 = 8'($urandom);
    fork
      begin
        send_rx(b, 1'b1);
        chk("R10 irq from rx full alone", 32'(irq), 32'd1);
        bus_read(2'd1, q);
        chk("R10 flags rx full, tx busy", q, flag_word(1'b1, 1'b0));
      end
      begin
        repeat (40) @(negedge clk);
        bus_write(2'd0, {24'h0, b2});
      end
      capture_tx(got, ok);
    join
    chk("R2 overlapped frame data", 32'(got), 32'(b2));
    bus_read(2'd0, q);
    chk("R5 overlapped rx data", q, {24'h0, b});

    // R7: overwrite of unread character
    b = 8'h5A; b2 = 8'hC3;
    send_rx(b, 1'b1);
    send_rx(b2, 1'b1);
    bus_read(2'd0, q);
    chk("R7 newest character kept", q, {24'h0, b2});

    // R8: short low pulse rejected
    @(negedge clk); rxd = 1'b0;
    repeat (CPB / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * CPB) @(negedge clk);
    bus_read(2'd1, q);
    chk("R8 runt ignored", q, flag_word(1'b0, 1'b1));

    // R9: low stop bit discards frame, then recovery
    send_rx(8'h81, 1'b0);
    repeat (2 * CPB) @(negedge clk);
    bus_read(2'd1, q);
    chk("R9 framing error discarded", q, flag_word(1'b0, 1'b1));
    b = 8'h6E;
    send_rx(b, 1'b1);
    bus_read(2'd0, q);
    chk("R9 recovery data", q, {24'h0, b});

    // R11: unmapped read and store to flag word
    bus_read(2'd2, q);
    chk("R11 unmapped read zero", q, 32'h0);
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd1, q);
    chk("R11 flag store ignored", q, flag_word(1'b0, 1'b1));
    chk("R11 tx idle after flag store", 32'(txd), 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule